// File: doc/BRIEF.md
# Adapter Command and Interrupt Front End

This block sits between a host bus and the receive and transmit engines of a network adapter. The host writes 16-bit command words to a single register offset. Each word carries a 5-bit command code and an 11-bit argument. The block decodes the command and turns it into single-cycle strobes for the receive and transmit units, a register-window selection, or updates to its own event and mask state.

A read of the same offset returns a status word. That word holds the selected window, a busy flag and the latched event bits, which are filtered by a read-visibility mask. The event bits are collected from single-cycle pulses sent by the surrounding units. They stay latched until the host acknowledges them with a bitmask. An interrupt-enable mask decides which latched events drive the level interrupt output.

Reset-type commands keep the block busy for a parameter number of cycles, and command writes that arrive during that time are dropped. The busy time gives downstream logic room to settle.

Top module: `cmd_irq_front`

## Requirements
- R1: A command word carries the code in bits 15..11 and the argument in bits 10..0. Argument bits a command does not use have no effect. Codes 2, 6, 7 and 16..31 change no state and raise no strobe.
- R2: Code 1 copies argument bits 2..0 into the current window, which status bits 15..13 report. Status bits 11..8 read zero.
- R3: Event pulses on evt_pulse bits 1..5 and 7 set the latched status bits at the same positions. Pulses on bits 0 and 6 are ignored. Code 12 sets status bit 6.
- R4: Code 13 clears every latched bit 1..7 whose argument bit is set, so an argument of 0xFF clears all of them. When an event pulse and an acknowledge hit the same bit in the same cycle, the bit stays set.
- R5: Code 14 loads argument bits 7..1 as the interrupt-enable mask, and argument bit 0 is ignored. Status bit 0 and irq are high exactly when some latched bit among 1..7 is also enabled.
- R6: Code 15 loads argument bits 7..0 as the read-visibility mask. A masked status bit reads zero but stays latched, and irq does not depend on this mask. Bits 15..12 are never masked.
- R7: Codes 3, 4, 5 and 8 pulse rx_disable_stb, rx_enable_stb, rx_reset_stb and rx_drop_stb. rx_on is set by code 4, cleared by codes 3, 5 and 0, and is low after power-up.
- R8: Codes 9, 10 and 11 pulse tx_enable_stb, tx_disable_stb and tx_reset_stb. tx_on is set by code 9, cleared by codes 10, 11 and 0, and is low after power-up.
- R9: Codes 0, 5, 8 and 11 hold status bit 12 high for BUSY_CYC cycles. Command writes made while bit 12 is high are ignored.
- R10: Code 0 and rst_n both return the block to its power-up state: window 0, no latched events, interrupt-enable mask 0, read-visibility mask 0xFF, receiver and transmitter off.
- R11: All effects of an accepted command appear in the cycle after the write edge. Each strobe is high for exactly that one cycle, and at most one strobe is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write to the shared offset |
| cmd_data | input | 16 | Command word: code 15..11, argument 10..0 |
| evt_pulse | input | 8 | Single-cycle event pulses, status bit positions |
| status | output | 16 | Status word returned on reads of the offset |
| irq | output | 1 | Level interrupt request |
| rx_on | output | 1 | Receiver enabled level |
| tx_on | output | 1 | Transmitter enabled level |
| rx_enable_stb | output | 1 | Receiver enable strobe |
| rx_disable_stb | output | 1 | Receiver disable strobe |
| rx_reset_stb | output | 1 | Receiver reset strobe |
| rx_drop_stb | output | 1 | Discard top received packet strobe |
| tx_enable_stb | output | 1 | Transmitter enable strobe |
| tx_disable_stb | output | 1 | Transmitter disable strobe |
| tx_reset_stb | output | 1 | Transmitter reset strobe |

## Verification
Every state change and strobe is registered at the edge that accepts a command or an event. The status word and irq are combinational from those registers, so all results are due one cycle after the stimulus edge. The bench drives on falling edges and samples one nanosecond after the accepting rising edge, against a model that it updates arithmetically at that point. The busy window closes BUSY_CYC edges after the accept edge, and the next write can only land on the edge after that. The bench counts edges to place one write on the last ignored edge and one on the first accepted edge.

// File: rtl/cmd_irq_front.sv
module cmd_irq_front #(
  parameter int BUSY_CYC = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [15:0] cmd_data,
  input  logic [7:0]  evt_pulse,
  output logic [15:0] status,
  output logic        irq,
  output logic        rx_on,
  output logic        tx_on,
  output logic        rx_enable_stb,
  output logic        rx_disable_stb,
  output logic        rx_reset_stb,
  output logic        rx_drop_stb,
  output logic        tx_enable_stb,
  output logic        tx_disable_stb,
  output logic        tx_reset_stb
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  localparam logic [4:0] OP_GRST = 5'd0,  OP_WIN = 5'd1,  OP_RXDIS = 5'd3, OP_RXEN = 5'd4,
                         OP_RXRST = 5'd5, OP_DROP = 5'd8, OP_TXEN = 5'd9,  OP_TXDIS = 5'd10,
                         OP_TXRST = 5'd11, OP_REQ = 5'd12, OP_ACK = 5'd13, OP_IEN = 5'd14,
                         OP_RDM = 5'd15;

  logic [2:0]    win;
  logic [7:1]    lat, ien;
  logic [7:0]    rdm;
  logic [CW-1:0] bcnt;

  wire        busy = bcnt != '0;
  wire [4:0]  op   = cmd_data[15:11];
  wire [10:0] arg  = cmd_data[10:0];
  wire        go   = cmd_wr && !busy;
  wire        grst = go && op == OP_GRST;
  wire        longop = go && (op == OP_GRST || op == OP_RXRST || op == OP_DROP || op == OP_TXRST);
  wire [7:1]  ev_set = {evt_pulse[7], go && op == OP_REQ, evt_pulse[5:1]};
  wire [7:1]  ev_clr = (go && op == OP_ACK) ? arg[7:1] : 7'd0;
  wire        pend = |(lat & ien);
  wire        unused_ok = &{1'b0, arg[10:8], evt_pulse[6], evt_pulse[0]};

  assign irq    = pend;
  assign status = {win, busy, 4'b0000, {lat, pend} & rdm};

  always_ff @(posedge clk) begin
    if (!rst_n || grst) begin
      win <= '0;
      lat <= '0;
      ien <= '0;
      rdm <= 8'hFF;
      rx_on <= 1'b0;
      tx_on <= 1'b0;
    end else begin
      lat <= (lat & ~ev_clr) | ev_set;
      if (go && op == OP_WIN) win <= arg[2:0];
      if (go && op == OP_IEN) ien <= arg[7:1];
      if (go && op == OP_RDM) rdm <= arg[7:0];
      if (go && op == OP_RXEN) rx_on <= 1'b1;
      else if (go && (op == OP_RXDIS || op == OP_RXRST)) rx_on <= 1'b0;
      if (go && op == OP_TXEN) tx_on <= 1'b1;
      else if (go && (op == OP_TXDIS || op == OP_TXRST)) tx_on <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bcnt <= '0;
    else if (longop) bcnt <= CW'(BUSY_CYC);
    else if (busy) bcnt <= bcnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_enable_stb  <= 1'b0;
      rx_disable_stb <= 1'b0;
      rx_reset_stb   <= 1'b0;
      rx_drop_stb    <= 1'b0;
      tx_enable_stb  <= 1'b0;
      tx_disable_stb <= 1'b0;
      tx_reset_stb   <= 1'b0;
    end else begin
      rx_enable_stb  <= go && op == OP_RXEN;
      rx_disable_stb <= go && op == OP_RXDIS;
      rx_reset_stb   <= go && op == OP_RXRST;
      rx_drop_stb    <= go && op == OP_DROP;
      tx_enable_stb  <= go && op == OP_TXEN;
      tx_disable_stb <= go && op == OP_TXDIS;
      tx_reset_stb   <= go && op == OP_TXRST;
    end
  end
endmodule

module cmd_irq_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic [15:0] cmd_data,
  input logic [7:0]  evt_pulse,
  input logic [15:0] status,
  input logic        irq,
  input logic        rx_on,
  input logic        tx_on,
  input logic        rx_enable_stb,
  input logic        rx_disable_stb,
  input logic        rx_reset_stb,
  input logic        rx_drop_stb,
  input logic        tx_enable_stb,
  input logic        tx_disable_stb,
  input logic        tx_reset_stb
);
  wire acc = cmd_wr && !status[12];

  AST_WIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_data[15:11] == 5'd1 |=> status[15:13] == $past(cmd_data[2:0])); // R2
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && status[12] |=> $stable(status[15:13])); // R9
  AST_ACK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_data == 16'h68FF && evt_pulse == 8'h00 |=> status[7:0] == 8'h00); // R4
  AST_IEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_data[15:11] == 5'd14 && cmd_data[7:1] == 7'd0 |=> !irq); // R5
  AST_DROP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_data[15:11] == 5'd8 |=> rx_drop_stb && status[12]); // R7
  AST_GLOBAL_RST: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_data[15:11] == 5'd0 |=> !rx_on && !tx_on && status[12] && status[15:13] == 3'd0); // R10
  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_enable_stb, rx_disable_stb, rx_reset_stb, rx_drop_stb,
              tx_enable_stb, tx_disable_stb, tx_reset_stb})); // R11
  AST_TX_EN: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_data[15:11] == 5'd9 |=> tx_on && tx_enable_stb); // R8
endmodule

bind cmd_irq_front cmd_irq_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data), .evt_pulse(evt_pulse),
  .status(status), .irq(irq), .rx_on(rx_on), .tx_on(tx_on),
  .rx_enable_stb(rx_enable_stb), .rx_disable_stb(rx_disable_stb), .rx_reset_stb(rx_reset_stb),
  .rx_drop_stb(rx_drop_stb), .tx_enable_stb(tx_enable_stb), .tx_disable_stb(tx_disable_stb),
  .tx_reset_stb(tx_reset_stb));

// File: tb/cmd_irq_front_tb.sv
module cmd_irq_front_tb;
  localparam int NB = 6;
  logic clk = 0, rst_n = 0, cmd_wr = 0;
  logic [15:0] cmd_data = 0;
  logic [7:0] evt_pulse = 0;
  logic [15:0] status;
  logic irq, rx_on, tx_on;
  logic rx_enable_stb, rx_disable_stb, rx_reset_stb, rx_drop_stb;
  logic tx_enable_stb, tx_disable_stb, tx_reset_stb;
  int total = 0, bad = 0;

  logic [2:0] m_win;
  logic [7:1] m_lat, m_ien;
  logic [7:0] m_rdm;
  logic m_rx, m_tx;

  always #4 clk = ~clk;

  cmd_irq_front #(.BUSY_CYC(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data), .evt_pulse(evt_pulse),
    .status(status), .irq(irq), .rx_on(rx_on), .tx_on(tx_on),
    .rx_enable_stb(rx_enable_stb), .rx_disable_stb(rx_disable_stb), .rx_reset_stb(rx_reset_stb),
    .rx_drop_stb(rx_drop_stb), .tx_enable_stb(tx_enable_stb), .tx_disable_stb(tx_disable_stb),
    .tx_reset_stb(tx_reset_stb));

  function automatic logic [6:0] stb_vec();
    return {rx_enable_stb, rx_disable_stb, rx_reset_stb, rx_drop_stb,
            tx_enable_stb, tx_disable_stb, tx_reset_stb};
  endfunction

  function automatic logic [6:0] exp_stb(input int c);
    case (c)
      4: return 7'b1000000;  3: return 7'b0100000;  5: return 7'b0010000;
      8: return 7'b0001000;  9: return 7'b0000100; 10: return 7'b0000010;
      11: return 7'b0000001;
      default: return 7'b0;
    endcase
  endfunction

  function automatic bit is_long(input int c);
    return c == 0 || c == 5 || c == 8 || c == 11;
  endfunction

  function automatic logic [15:0] exp_status(input bit busy);
    logic pend = |(m_lat & m_ien);
    return {m_win, busy, 4'b0000, {m_lat, pend} & m_rdm};
  endfunction

  task automatic model_reset();
    m_win = 0; m_lat = 0; m_ien = 0; m_rdm = 8'hFF; m_rx = 0; m_tx = 0;
  endtask

  task automatic model_cmd(input int c, input logic [10:0] a);
    case (c)
      0: model_reset();
      1: m_win = a[2:0];
      3, 5: m_rx = 0;
      4: m_rx = 1;
      9: m_tx = 1;
      10, 11: m_tx = 0;
      12: m_lat[6] = 1;
      13: m_lat = m_lat & ~a[7:1];
      14: m_ien = a[7:1];
      15: m_rdm = a[7:0];
      default: ;
    endcase
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic cmd(input int c, input logic [10:0] a);
    @(negedge clk); cmd_wr = 1; cmd_data = {c[4:0], a};
    @(posedge clk); #1; cmd_wr = 0;
  endtask

  task automatic pulse(input logic [7:0] e);
    @(negedge clk); evt_pulse = e;
    @(posedge clk); #1; evt_pulse = 0;
    m_lat = m_lat | {e[7], 1'b0, e[5:1]};
  endtask

  task automatic run_cmd(input int c, input logic [10:0] a);
    cmd(c, a); model_cmd(c, a);
    if (is_long(c)) repeat (NB) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R10 reset state
    check("R10 reset status", status, 16'h0000);
    check("R10 reset levels", {irq, rx_on, tx_on}, 3'b000);

    // R1 R7 R8 R11: every code, argument zero
    for (int c = 0; c < 32; c++) begin
      cmd(c, 11'h000); model_cmd(c, 11'h000);
      check($sformatf("R1 R7 R8 strobes code %0d", c), stb_vec(), exp_stb(c));
      check($sformatf("R7 R8 levels code %0d", c), {rx_on, tx_on}, {m_rx, m_tx});
      check($sformatf("R9 status code %0d", c), status, exp_status(is_long(c)));
      tick();
      check($sformatf("R11 strobe width code %0d", c), stb_vec(), 7'b0);
      if (is_long(c)) repeat (NB - 1) tick();
    end
    run_cmd(0, 0);

    // R2 window sweep with upper argument bits set
    for (int w = 0; w < 8; w++) begin
      run_cmd(1, {8'hA5, w[2:0]});
      check($sformatf("R2 window %0d", w), status, exp_status(0));
    end

    // R3 single events
    for (int b = 0; b < 8; b++) begin
      run_cmd(13, 11'h0FF);
      pulse(8'(1 << b));
      check($sformatf("R3 event bit %0d", b), status, exp_status(0));
    end
    run_cmd(13, 11'h0FF);
    run_cmd(12, 0);
    check("R3 request command", status, exp_status(0));

    // R4 acknowledge every subset
    for (int s = 0; s < 256; s++) begin
      pulse(8'hBE); run_cmd(12, 0);
      run_cmd(13, {3'b111, s[7:0]});
      check($sformatf("R4 ack %02h", s), status, exp_status(0));
    end
    // R4 event wins over simultaneous ack
    run_cmd(13, 11'h0FF);
    @(negedge clk); evt_pulse = 8'h10; cmd_wr = 1; cmd_data = {5'd13, 11'h0FF};
    @(posedge clk); #1; cmd_wr = 0; evt_pulse = 0;
    m_lat = 7'h08;
    check("R4 event beats ack", status, exp_status(0));

    // R5 interrupt enable per bit
    for (int b = 1; b < 8; b++) begin
      if (b == 6) continue;
      run_cmd(13, 11'h0FF);
      run_cmd(14, 11'(1 << b) | 11'h001);
      pulse(8'(1 << ((b == 7) ? 1 : b + 1)));
      check($sformatf("R5 other bit %0d irq", b), irq, 1'b0);
      pulse(8'(1 << b));
      check($sformatf("R5 enabled bit %0d irq", b), irq, 1'b1);
      check($sformatf("R5 status bit0 %0d", b), status, exp_status(0));
      run_cmd(13, 11'(1 << b));
      check($sformatf("R5 acked bit %0d irq", b), irq, 1'b0);
    end

    // R6 read mask sweep
    pulse(8'hBE); run_cmd(12, 0); run_cmd(14, 11'h0FE);
    for (int m = 0; m < 256; m++) begin
      run_cmd(15, {3'b010, m[7:0]});
      check($sformatf("R6 mask %02h", m), status, exp_status(0));
    end
    run_cmd(15, 0);
    check("R6 irq ignores read mask", irq, 1'b1);
    run_cmd(15, 11'h0FF);
    check("R6 bits kept latched", status, exp_status(0));

    // R9 busy window boundaries
    run_cmd(1, 11'h002);
    cmd(5, 0); model_cmd(5, 0);
    check("R9 busy after rx reset", status[12], 1'b1);
    repeat (NB - 1) tick();
    cmd(1, 11'h006);
    check("R9 write on last busy edge ignored", status, exp_status(0));
    cmd(1, 11'h006); model_cmd(1, 11'h006);
    check("R9 first write after busy accepted", status, exp_status(0));

    // R10 global reset by command
    run_cmd(4, 0); run_cmd(9, 0); run_cmd(14, 11'h0FE); run_cmd(15, 11'h00F);
    cmd(0, 11'h7FF); model_cmd(0, 0);
    check("R10 command reset status", status, exp_status(1));
    check("R10 command reset levels", {irq, rx_on, tx_on}, 3'b000);
    repeat (NB) tick();
    check("R10 busy clears", status, 16'h0000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule